// File: doc/BRIEF.md
# Eight-Entry Word FIFO with Wrapped Occupancy Field

A synchronous first-in first-out buffer holding eight nine-bit words, placed between a register interface and a serial shifter. One instance serves the transmit direction and a second serves the receive direction. Words enter through a push strobe. They leave through a pop strobe, and the popped word is presented on a registered output one cycle later.

The occupancy is reported through a field only three bits wide. It reads 0 both when the buffer is empty and when it holds all eight words. Software tells the two cases apart with the full flag and the non-empty (data-ready) flag. For example, free transmit space is eight minus the field, and that formula is only valid while the full flag is low.

A half-full flag can drive an interrupt. Sticky flags record pushes lost to a full buffer and pops from an empty one. A synchronous soft clear flushes the buffer. A clear issued while words are still held raises a sticky busy error.

Top module: `fifo8_wrapcount`

## Requirements
- R1: Words are popped in the order they were pushed, each word 9 bits wide, with up to 8 words held.
- R2: `level` equals the number of held words modulo 8, so it reads 0 when all 8 words are held.
- R3: `full` is 1 exactly when 8 words are held.
- R4: `half` is 1 exactly when 4 or more words are held.
- R5: `ready` is 1 exactly when at least one word is held.
- R6: A push while 8 words are held is ignored: the contents and `level` are unchanged, and `ovf` goes to 1 and stays there until a soft clear or reset.
- R7: A pop while empty leaves `pop_data` at its previous value, and `udf` goes to 1 and stays there until a soft clear or reset.
- R8: A push and a pop in the same cycle, with between 1 and 7 words held, perform both operations and leave the occupancy unchanged.
- R9: `pop_data` shows the popped word in the cycle after the pop strobe and holds its value otherwise.
- R10: `soft_clr` empties the buffer and clears `ovf` and `udf`, and it overrides any push or pop in the same cycle.
- R11: `soft_clr` while words are held sets `busy_err` to 1. `soft_clr` while empty sets `busy_err` to 0.
- R12: After `rst_n` is low, the buffer is empty, all flags are 0 and `pop_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous flush |
| push | input | 1 | Write strobe |
| push_data | input | 9 | Word to write |
| pop | input | 1 | Read strobe |
| pop_data | output | 9 | Last popped word, registered |
| level | output | 3 | Occupancy modulo 8 |
| full | output | 1 | Eight words held |
| half | output | 1 | Four or more words held |
| ready | output | 1 | At least one word held |
| ovf | output | 1 | Sticky: push lost to a full buffer |
| udf | output | 1 | Sticky: pop from an empty buffer |
| busy_err | output | 1 | Sticky: flush issued while not empty |

## Verification
Some behaviours are checked on every cycle by the assertions, in terms of the occupancy counter:
- the one-step occupancy changes, and the unchanged occupancy on a combined push and pop;
- the rule that a push to a full buffer is dropped and raises `ovf`;
- the held `pop_data` and raised `udf` on an empty pop;
- the flush outcome and the busy error.

Other behaviours only the bench scenarios can show. These are the word order through wrap-around of the storage pointers, and the reading of `level` as 0 at eight entries next to `full`. They also include the correct word emerging after mixed push and pop sequences, which the scoreboard compares item by item.

// File: rtl/fifo8_wrapcount.sv
module fifo8_wrapcount #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic [$clog2(DEPTH)-1:0] level,
  output logic             full,
  output logic             half,
  output logic             ready,
  output logic             ovf,
  output logic             udf,
  output logic             busy_err
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH/2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      cnt;
  logic             do_push, do_pop;

  assign full    = (cnt == CNT_FULL);
  assign half    = (cnt >= CNT_HALF);
  assign ready   = (cnt != '0);
  assign level   = cnt[AW-1:0];
  assign do_push = push && !full && !soft_clr;
  assign do_pop  = pop && ready && !soft_clr;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      pop_data <= '0;
      ovf      <= 1'b0;
      udf      <= 1'b0;
      busy_err <= 1'b0;
    end else if (soft_clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      ovf      <= 1'b0;
      udf      <= 1'b0;
      busy_err <= ready;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr   <= rd_ptr + 1'b1;
        pop_data <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && full) ovf <= 1'b1;
      if (pop && !ready) udf <= 1'b1;
    end
  end

  // R6
  full_push_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full && !soft_clr) |=> (ovf && full));
  // R7
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !ready && !soft_clr) |=> (udf && $stable(pop_data)));
  // R8
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && ready && !full && !soft_clr) |=> $stable(cnt));
  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full && !soft_clr) |=> (cnt == $past(cnt) + 1'b1));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!ready && !ovf && !udf));
  // R11
  flush_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clr && ready) |=> busy_err);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !soft_clr) |=> $stable(pop_data));
endmodule

// File: tb/fifo8_wrapcount_tb.sv
module fifo8_wrapcount_tb;
  logic clk = 0, rst_n = 0;
  logic soft_clr = 0, push = 0, pop = 0;
  logic [8:0] push_data = '0;
  logic [8:0] pop_data;
  logic [2:0] level;
  logic full, half, ready, ovf, udf, busy_err;

  fifo8_wrapcount u_dut (.clk, .rst_n, .soft_clr, .push, .push_data, .pop,
    .pop_data, .level, .full, .half, .ready, .ovf, .udf, .busy_err);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [8:0] mq[$];
  logic [8:0] exp_q[$];
  logic [8:0] last_out = '0;
  logic m_ovf = 0, m_udf = 0, m_berr = 0;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares popped words as they appear
  always @(negedge clk) begin
    while (exp_q.size() != 0) chk(16'(pop_data), 16'(exp_q.pop_front()), "R1/R7/R9 pop_data");
  end

  task automatic check_flags();
    int sz = mq.size();
    chk(16'(level), 16'(sz % 8), "R2 level");
    chk(16'(full), 16'(sz == 8), "R3 full");
    chk(16'(half), 16'(sz >= 4), "R4 half");
    chk(16'(ready), 16'(sz != 0), "R5 ready");
    chk(16'(ovf), 16'(m_ovf), "R6 ovf");
    chk(16'(udf), 16'(m_udf), "R7 udf");
    chk(16'(busy_err), 16'(m_berr), "R11 busy_err");
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic step(input logic p, input logic [8:0] d, input logic q, input logic c);
    int sz;
    logic [8:0] w;
    push = p; push_data = d; pop = q; soft_clr = c;
    @(posedge clk); #1;
    push = 0; pop = 0; soft_clr = 0;
    sz = mq.size();
    if (c) begin
      m_berr = (sz != 0); m_ovf = 0; m_udf = 0; mq.delete();
    end else begin
      if (q && sz == 0) begin m_udf = 1; exp_q.push_back(last_out); end
      if (q && sz > 0) begin w = mq.pop_front(); last_out = w; exp_q.push_back(w); end
      if (p && sz == 8) m_ovf = 1;
      if (p && sz < 8) mq.push_back(d);
    end
    @(negedge clk);
    check_flags();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(16'(pop_data), 16'h0, "R12 pop_data");
    check_flags();
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) step(1, 9'(9'h1A0 + i), 0, 0);   // R1
    for (int i = 0; i < 5; i++) step(0, '0, 1, 0);
    for (int i = 0; i < 8; i++) step(1, 9'(i * 37 + 3), 0, 0);   // R2 R3 wrap
    step(1, 9'h1FF, 0, 0);                                     // R6
    step(1, 9'h155, 1, 0);                                     // full: pop only
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0);
    for (int i = 0; i < 4; i++) step(1, 9'(9'h0F0 + i), 1, 0); // R8
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0);
    step(0, '0, 0, 0);                                         // R9 hold
    step(0, '0, 1, 0);                                         // R7
    step(1, 9'h0AA, 1, 0);                                     // empty: push only
    step(1, 9'h0BB, 0, 0);
    step(1, 9'h0CC, 1, 1);                                     // R10 R11
    step(1, 9'h011, 0, 0);
    step(0, '0, 1, 0);
    step(0, '0, 0, 1);                                         // R11 clear
    step(0, '0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule